// File: doc/BRIEF.md
# Console I/O Register Controller

This block sits beside main memory on the address and data bus of a 16-bit processor. It decodes five device addresses and holds the registers behind them: a keyboard status word and character latch, a display status word and outgoing character, and a machine control word. Every other load or store is steered to main memory. For a device address, the read data path returns the device value instead of the memory value.

Each status word carries its ready flag in bit 15, so a polled value reads as negative once the device is ready. Software waits in a loop while the value is zero or positive. Characters arrive from a keyboard model as a byte strobe. Characters leave toward a display model on a valid/accept handshake. Bit 15 of the machine control word drives the run enable that gates instruction execution. Software stops the machine by masking that bit to zero and writing the word back.

Bus reads are combinational: `rdata` and `mem_sel` follow the address and strobes in the same cycle. Writes, read side effects and byte arrivals take effect at the next rising clock edge.

Top module: `cio_console`

## Requirements
- R1: The device addresses are 0xFE00 (keyboard status), 0xFE02 (keyboard character), 0xFE04 (display status), 0xFE06 (display character) and 0xFFFE (machine control). For any other address, `rdata` equals `mem_rdata`, and `mem_sel` is high whenever `bus_rd` or `bus_wr` is high. For a device address, `mem_sel` stays low.
- R2: A read of the keyboard status word returns the keyboard ready flag in bit 15 and zero in bits 14..0.
- R3: When `kbd_valid` is high at a clock edge, the keyboard ready flag is set and `kbd_byte` is latched. A read of the keyboard character returns the latched byte in bits 7..0 and zero in bits 15..8.
- R4: A read of the keyboard character clears the keyboard ready flag at the next edge. If a byte arrives in the same cycle, the arrival wins: the flag stays set and the new byte is latched.
- R5: A read of the display status word returns the display ready flag in bit 15 and zeros elsewhere. A read of the display character returns zero. A write to the display character while the flag is set clears the flag, places bits 7..0 of the data on `disp_byte`, and raises `disp_valid` (equal to the inverse of the flag) one edge later.
- R6: While `disp_valid` is high and `disp_accept` is low, `disp_byte` and `disp_valid` hold. An edge with `disp_accept` high sets the display ready flag again. `disp_accept` while nothing is pending has no effect.
- R7: A write to the display character while the display flag is clear is discarded. `disp_byte` keeps the pending byte.
- R8: The machine control word is fully writable and reads back all 16 bits. `run_en` equals its bit 15, so a write of 0x7FFF stops the machine.
- R9: Writes to the keyboard status word, the keyboard character and the display status word change no state.
- R10: After reset the machine control word is 0x8000 (`run_en` high), the display ready flag is set, the keyboard ready flag is clear and the latched keyboard byte is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Load strobe |
| bus_wr | input | 1 | Store strobe |
| bus_wdata | input | 16 | Store data |
| mem_rdata | input | 16 | Read data from main memory |
| rdata | output | 16 | Steered read data to the processor |
| mem_sel | output | 1 | Access is routed to main memory |
| kbd_valid | input | 1 | Keyboard byte strobe |
| kbd_byte | input | 8 | Keyboard character |
| disp_valid | output | 1 | Display character pending |
| disp_byte | output | 8 | Display character |
| disp_accept | input | 1 | Display takes the pending character |
| run_en | output | 1 | Machine run enable |

## Verification
`rdata` and `mem_sel` are due in the same cycle as the address and strobes. Flag, latch and control-word changes are due one edge after the write, read or strobe that causes them. The bench drives inputs just after a rising edge and compares every output with its behavioural model at the following falling edge. The model advances only at the rising edge, using the inputs that were applied there. Directed checks read a register in the cycle after the action that should have changed it. In this way, ignored writes and handshake holds are seen through the bus read path or on the display pins.

// File: rtl/cio_pkg.sv
package cio_pkg;

    localparam int CIO_DATA_W = 16;
    localparam int CIO_CHAR_W = 8;

    localparam logic [CIO_DATA_W-1:0] CIO_KSTAT_ADDR = 16'hFE00;
    localparam logic [CIO_DATA_W-1:0] CIO_KCHAR_ADDR = 16'hFE02;
    localparam logic [CIO_DATA_W-1:0] CIO_DSTAT_ADDR = 16'hFE04;
    localparam logic [CIO_DATA_W-1:0] CIO_DCHAR_ADDR = 16'hFE06;
    localparam logic [CIO_DATA_W-1:0] CIO_MCTL_ADDR  = 16'hFFFE;
    localparam logic [CIO_DATA_W-1:0] CIO_MCTL_RESET = 16'h8000;

    typedef struct packed {
        logic kstat;
        logic kchar;
        logic dstat;
        logic dchar;
        logic mctl;
    } cio_hit_t;

    typedef struct packed {
        logic                  rdy;
        logic [CIO_CHAR_W-1:0] chr;
    } cio_chan_t;

    function automatic logic [CIO_DATA_W-1:0] cio_status_word(input logic rdy);
        logic [CIO_DATA_W-1:0] w;
        w = '0;
        w[CIO_DATA_W-1] = rdy;
        return w;
    endfunction

endpackage

// File: rtl/cio_decode.sv
module cio_decode
    import cio_pkg::*;
#(
    parameter int                  DATA_W     = CIO_DATA_W,
    parameter logic [DATA_W-1:0]   KSTAT_ADDR = CIO_KSTAT_ADDR,
    parameter logic [DATA_W-1:0]   KCHAR_ADDR = CIO_KCHAR_ADDR,
    parameter logic [DATA_W-1:0]   DSTAT_ADDR = CIO_DSTAT_ADDR,
    parameter logic [DATA_W-1:0]   DCHAR_ADDR = CIO_DCHAR_ADDR,
    parameter logic [DATA_W-1:0]   MCTL_ADDR  = CIO_MCTL_ADDR
) (
    input  logic [DATA_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output cio_hit_t          hit,
    output logic              dev_any,
    output logic              mem_sel
);

    always_comb begin
        hit.kstat = (addr == KSTAT_ADDR);
        hit.kchar = (addr == KCHAR_ADDR);
        hit.dstat = (addr == DSTAT_ADDR);
        hit.dchar = (addr == DCHAR_ADDR);
        hit.mctl  = (addr == MCTL_ADDR);
        dev_any   = |hit;
        mem_sel   = (rd | wr) & ~dev_any;
    end

endmodule

// File: rtl/cio_kbd_port.sv
module cio_kbd_port
    import cio_pkg::*;
#(
    parameter int CHAR_W = CIO_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_rd,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_byte,
    output logic              rdy,
    output logic [CHAR_W-1:0] chr
);

    cio_chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.rdy = 1'b1;
            st_d.chr = in_byte;
        end else if (char_rd) begin
            st_d.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy = st_q.rdy;
    assign chr = st_q.chr;

endmodule

// File: rtl/cio_disp_port.sv
module cio_disp_port
    import cio_pkg::*;
#(
    parameter int CHAR_W = CIO_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_wr,
    input  logic [CHAR_W-1:0] wr_byte,
    input  logic              accept,
    output logic              rdy,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_byte
);

    cio_chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.rdy) begin
            if (char_wr) begin
                st_d.rdy = 1'b0;
                st_d.chr = wr_byte;
            end
        end else if (accept) begin
            st_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rdy <= 1'b1;
            st_q.chr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy       = st_q.rdy;
    assign out_valid = ~st_q.rdy;
    assign out_byte  = st_q.chr;

endmodule

// File: rtl/cio_ctl_reg.sv
module cio_ctl_reg
    import cio_pkg::*;
#(
    parameter int                DATA_W    = CIO_DATA_W,
    parameter logic [DATA_W-1:0] RESET_VAL = CIO_MCTL_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              run
);

    logic [DATA_W-1:0] ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) ctl_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= RESET_VAL;
        else        ctl_q <= ctl_d;
    end

    assign value = ctl_q;
    assign run   = ctl_q[DATA_W-1];

endmodule

// File: rtl/cio_console.sv
module cio_console
    import cio_pkg::*;
#(
    parameter int                DATA_W     = CIO_DATA_W,
    parameter int                CHAR_W     = CIO_CHAR_W,
    parameter logic [DATA_W-1:0] KSTAT_ADDR = CIO_KSTAT_ADDR,
    parameter logic [DATA_W-1:0] KCHAR_ADDR = CIO_KCHAR_ADDR,
    parameter logic [DATA_W-1:0] DSTAT_ADDR = CIO_DSTAT_ADDR,
    parameter logic [DATA_W-1:0] DCHAR_ADDR = CIO_DCHAR_ADDR,
    parameter logic [DATA_W-1:0] MCTL_ADDR  = CIO_MCTL_ADDR,
    parameter logic [DATA_W-1:0] MCTL_RESET = CIO_MCTL_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_sel,
    input  logic              kbd_valid,
    input  logic [CHAR_W-1:0] kbd_byte,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte,
    input  logic              disp_accept,
    output logic              run_en
);

    localparam int PAD_W = DATA_W - CHAR_W;

    cio_hit_t          hit;
    logic              dev_any;
    logic              kbd_rdy;
    logic [CHAR_W-1:0] kbd_chr;
    logic              disp_rdy;
    logic [DATA_W-1:0] mctl_val;

    cio_decode #(
        .DATA_W     (DATA_W),
        .KSTAT_ADDR (KSTAT_ADDR),
        .KCHAR_ADDR (KCHAR_ADDR),
        .DSTAT_ADDR (DSTAT_ADDR),
        .DCHAR_ADDR (DCHAR_ADDR),
        .MCTL_ADDR  (MCTL_ADDR)
    ) u_decode (
        .addr    (bus_addr),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .hit     (hit),
        .dev_any (dev_any),
        .mem_sel (mem_sel)
    );

    cio_kbd_port #(.CHAR_W(CHAR_W)) u_kbd (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_rd  (bus_rd & hit.kchar),
        .in_valid (kbd_valid),
        .in_byte  (kbd_byte),
        .rdy      (kbd_rdy),
        .chr      (kbd_chr)
    );

    cio_disp_port #(.CHAR_W(CHAR_W)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_wr   (bus_wr & hit.dchar),
        .wr_byte   (bus_wdata[CHAR_W-1:0]),
        .accept    (disp_accept),
        .rdy       (disp_rdy),
        .out_valid (disp_valid),
        .out_byte  (disp_byte)
    );

    cio_ctl_reg #(
        .DATA_W    (DATA_W),
        .RESET_VAL (MCTL_RESET)
    ) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr & hit.mctl),
        .wdata (bus_wdata),
        .value (mctl_val),
        .run   (run_en)
    );

    always_comb begin
        rdata = mem_rdata;
        if (dev_any) begin
            rdata = '0;
            if (hit.kstat) rdata = cio_status_word(kbd_rdy);
            if (hit.kchar) rdata = {{PAD_W{1'b0}}, kbd_chr};
            if (hit.dstat) rdata = cio_status_word(disp_rdy);
            if (hit.mctl)  rdata = mctl_val;
        end
    end

endmodule

// File: rtl/cio_console_chk.sv
module cio_console_chk
    import cio_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [CIO_DATA_W-1:0] bus_addr,
    input logic                  bus_rd,
    input logic                  bus_wr,
    input logic                  mem_sel,
    input logic                  kbd_valid,
    input logic                  kbd_rdy,
    input logic                  disp_valid,
    input logic [CIO_CHAR_W-1:0] disp_byte,
    input logic                  disp_accept,
    input logic                  run_en
);

    logic at_dev;
    assign at_dev = (bus_addr == CIO_KSTAT_ADDR) || (bus_addr == CIO_KCHAR_ADDR) ||
                    (bus_addr == CIO_DSTAT_ADDR) || (bus_addr == CIO_DCHAR_ADDR) ||
                    (bus_addr == CIO_MCTL_ADDR);

    AST_DEV_NOT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        at_dev |-> !mem_sel); // R1

    AST_KBD_ARRIVE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_valid |=> kbd_rdy); // R3

    AST_KBD_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CIO_KCHAR_ADDR && !kbd_valid) |=> !kbd_rdy); // R4

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_accept) |=> (disp_valid && $stable(disp_byte))); // R6

    AST_DISP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_accept) |=> !disp_valid); // R6

    AST_DISP_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && bus_wr && bus_addr == CIO_DCHAR_ADDR) |=> $stable(disp_byte)); // R7

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == CIO_MCTL_ADDR) |=> $stable(run_en)); // R8

endmodule

bind cio_console cio_console_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .mem_sel     (mem_sel),
    .kbd_valid   (kbd_valid),
    .kbd_rdy     (kbd_rdy),
    .disp_valid  (disp_valid),
    .disp_byte   (disp_byte),
    .disp_accept (disp_accept),
    .run_en      (run_en)
);

// File: tb/test_cio_console.sv
module test_cio_console;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] rdata;
    logic        mem_sel;
    logic        kbd_valid = 1'b0;
    logic [7:0]  kbd_byte = '0;
    logic        disp_valid;
    logic [7:0]  disp_byte;
    logic        disp_accept = 1'b0;
    logic        run_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // behavioural reference state
    bit        m_krdy;
    bit [7:0]  m_kchr;
    bit        m_drdy;
    bit [7:0]  m_dchr;
    bit [15:0] m_ctl;

    // optional directed rdata check for the next falling edge
    bit          d_en = 0;
    string       d_req;
    logic [15:0] d_exp;

    always #5 clk = ~clk;

    cio_console i_cio_console (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mem_rdata(mem_rdata),
        .rdata(rdata), .mem_sel(mem_sel), .kbd_valid(kbd_valid),
        .kbd_byte(kbd_byte), .disp_valid(disp_valid), .disp_byte(disp_byte),
        .disp_accept(disp_accept), .run_en(run_en)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit is_dev(input logic [15:0] a);
        return a == 16'hFE00 || a == 16'hFE02 || a == 16'hFE04 ||
               a == 16'hFE06 || a == 16'hFFFE;
    endfunction

    task automatic compare_all();
        logic [15:0] exp_rd;
        string       rq;
        case (bus_addr)
            16'hFE00: begin exp_rd = {m_krdy, 15'h0};  rq = "R2"; end
            16'hFE02: begin exp_rd = {8'h00, m_kchr};  rq = "R3"; end
            16'hFE04: begin exp_rd = {m_drdy, 15'h0};  rq = "R5"; end
            16'hFE06: begin exp_rd = 16'h0000;         rq = "R5"; end
            16'hFFFE: begin exp_rd = m_ctl;            rq = "R8"; end
            default:  begin exp_rd = mem_rdata;        rq = "R1"; end
        endcase
        check(rq, rdata, exp_rd);
        check("R1 mem_sel", {15'h0, mem_sel}, {15'h0, (bus_rd | bus_wr) & !is_dev(bus_addr)});
        check("R5 disp_valid", {15'h0, disp_valid}, {15'h0, !m_drdy});
        check("R5 disp_byte", {8'h0, disp_byte}, {8'h0, m_dchr});
        check("R8 run_en", {15'h0, run_en}, {15'h0, m_ctl[15]});
    endtask

    task automatic model_reset();
        m_krdy = 0; m_kchr = 8'h00; m_drdy = 1; m_dchr = 8'h00; m_ctl = 16'h8000;
    endtask

    task automatic model_edge();
        if (kbd_valid) begin
            m_krdy = 1; m_kchr = kbd_byte;
        end else if (bus_rd && bus_addr == 16'hFE02) begin
            m_krdy = 0;
        end
        if (m_drdy) begin
            if (bus_wr && bus_addr == 16'hFE06) begin
                m_drdy = 0; m_dchr = bus_wdata[7:0];
            end
        end else if (disp_accept) begin
            m_drdy = 1;
        end
        if (bus_wr && bus_addr == 16'hFFFE) m_ctl = bus_wdata;
    endtask

    // one cycle: compare at falling edge, advance model at rising edge
    task automatic tick();
        @(negedge clk);
        compare_all();
        if (d_en) begin
            check(d_req, rdata, d_exp);
            d_en = 0;
        end
        @(posedge clk);
        model_edge();
        #1;
        bus_rd = 0; bus_wr = 0; kbd_valid = 0; disp_accept = 0;
    endtask

    task automatic rd(input logic [15:0] a, input string req, input logic [15:0] exp);
        bus_addr = a; bus_rd = 1; d_en = 1; d_req = req; d_exp = exp;
        tick();
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] v);
        bus_addr = a; bus_wr = 1; bus_wdata = v;
        tick();
    endtask

    initial begin : watchdog
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected done", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R10: reset state
        rd(16'hFFFE, "R10 ctl", 16'h8000);
        check("R10 run_en", {15'h0, run_en}, 16'h0001);
        rd(16'hFE04, "R10 disp ready", 16'h8000);
        rd(16'hFE00, "R10 kbd not ready", 16'h0000);
        rd(16'hFE02, "R10 kbd byte", 16'h0000);

        // R1: memory pass-through
        mem_rdata = 16'h1234;
        rd(16'h3000, "R1 mem read", 16'h1234);
        mem_rdata = 16'hBEEF;
        rd(16'hFE01, "R1 near-device address", 16'hBEEF);
        wr(16'h4000, 16'h5555);

        // R2/R3: arrival
        kbd_valid = 1; kbd_byte = 8'h41; bus_addr = 16'h0000;
        tick();
        rd(16'hFE00, "R2 kbd ready", 16'h8000);
        rd(16'hFE02, "R3 kbd byte", 16'h0041);
        // R4: the read above clears ready
        rd(16'hFE00, "R4 cleared after read", 16'h0000);

        // R4: arrival and read in the same cycle
        kbd_valid = 1; kbd_byte = 8'h7A;
        tick();
        kbd_valid = 1; kbd_byte = 8'hC3;
        rd(16'hFE02, "R4 old byte during race", 16'h007A);
        rd(16'hFE00, "R4 arrival wins", 16'h8000);
        rd(16'hFE02, "R4 new byte latched", 16'h00C3);

        // R5: display write
        wr(16'hFE06, 16'h1F5A);
        check("R5 valid", {15'h0, disp_valid}, 16'h0001);
        check("R5 byte", {8'h0, disp_byte}, 16'h005A);
        rd(16'hFE04, "R5 busy status", 16'h0000);
        rd(16'hFE06, "R5 char reads zero", 16'h0000);

        // R7: write while busy dropped
        wr(16'hFE06, 16'h0033);
        check("R7 byte kept", {8'h0, disp_byte}, 16'h005A);
        // R6: hold, then accept
        tick(); tick();
        check("R6 held valid", {15'h0, disp_valid}, 16'h0001);
        disp_accept = 1;
        tick();
        check("R6 released", {15'h0, disp_valid}, 16'h0000);
        rd(16'hFE04, "R6 ready again", 16'h8000);
        // R6: accept while idle has no effect
        disp_accept = 1;
        tick();
        check("R6 idle accept", {15'h0, disp_valid}, 16'h0000);
        wr(16'hFE06, 16'h0042);
        disp_accept = 1;
        tick();
        check("R5 second char", {8'h0, disp_byte}, 16'h0042);

        // R9: writes to read-only words
        wr(16'hFE00, 16'hFFFF);
        rd(16'hFE00, "R9 kbd status", 16'h0000);
        wr(16'hFE02, 16'h0099);
        rd(16'hFE02, "R9 kbd char", 16'h00C3);
        wr(16'hFE04, 16'h0000);
        rd(16'hFE04, "R9 disp status", 16'h8000);
        check("R9 no display send", {15'h0, disp_valid}, 16'h0000);

        // R8: machine control
        wr(16'hFFFE, 16'h7FFF);
        check("R8 halted", {15'h0, run_en}, 16'h0000);
        rd(16'hFFFE, "R8 readback", 16'h7FFF);
        wr(16'hFFFE, 16'h8123);
        check("R8 running", {15'h0, run_en}, 16'h0001);
        rd(16'hFFFE, "R8 readback 2", 16'h8123);

        repeat (4) tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule